// File: doc/BRIEF.md
# Low-Power Mode Register and Power-State Tracker

This block is the device-side control logic of a 1M x 16 pseudo-static RAM. It watches the chip strobes and a low-power pin (`lp_n`, active low). It holds a five-bit low-power configuration register and tracks the device's power state: active, standby, arming, register-set, partial-refresh, reduced-size, deep power-down and recovery. Time is measured by a microsecond tick from the surrounding chip, so every window is a count of ticks.

The configuration register is not written through the data bus. It is loaded from the low five address bits by a write cycle that begins while `lp_n` is low and inside the arming window. It takes effect on the next rising edge of `lp_n`. If `lp_n` falls and no write arrives inside the window, the device drops into the power-saving state that the register selects. For the address on `addr`, the block reports whether that word keeps its data under the current configuration and state. A `ready` flag falls during deep power-down and its recovery, and a sticky `err` records protocol violations.

Top module: `lpm_ctrl`

## Requirements
- R1: While and after reset, `state` is STANDBY, `ready` is 1, `err` is 0, and the register holds its default 5'h10. The register fields are: bit 4 deep-power-down off (0 enables it), bit 3 reduced-size select, bit 2 top-half select, bits 1:0 area code.
- R2: The `state` encoding is ACTIVE=0, STANDBY=1, ARM=2, REGSET=3, PAR=4, RMS=5, DPD=6, RECOVER=7, and the state is registered. From ACTIVE or STANDBY with `lp_n` high, the next state is ACTIVE when `cs_n` is low and at least one of `ub_n`/`lb_n` is low. Otherwise it is STANDBY.
- R3: A falling `lp_n` seen from ACTIVE or STANDBY moves to ARM. In ARM, a write strobe (`cs_n`, `we_n` and at least one byte enable low) captures `addr[4:0]` and moves to REGSET. The captured value becomes the register on the clock where `lp_n` is high in REGSET. Write strobes while `lp_n` is high never alter the register.
- R4: When the write strobe falls in the same cycle in which the arming window has just expired, the register-set cycle wins and the next state is REGSET.
- R5: In ARM, once WIN_US ticks have been counted without a write, the next state is DPD if bit 4 is 0, else RMS if bit 3 is 1, else PAR. A rising `lp_n` in ARM returns to the idle state of R2.
- R6: Leaving PAR, RMS or DPD after fewer than MIN_LP_US ticks in that state sets `err`.
- R7: `lp_n` rising in DPD moves to RECOVER and restores the register to 5'h10. RECOVER returns to idle after RECOVER_US ticks, and `ready` is 0 throughout DPD and RECOVER.
- R8: The reduced-size setting stays in the register across later `lp_n` cycles that carry no register write, so each later entry lands in RMS again.
- R9: Retention by area code: 00 and the reserved 01 cover the full array. 10 covers `addr[19]` equal to bit 2, which is 0x00000–0x7FFFF or 0x80000–0xFFFFF. 11 covers `addr[19:18]` equal to bit 2 repeated, which is 0x00000–0x3FFFF or 0xC0000–0xFFFFF. The limit applies in PAR, and in every non-power-down state when bit 3 is 1. Otherwise `retained` is 1.
- R10: `retained` is 0 for every address in DPD and RECOVER.
- R11: An access (`cs_n` low with a byte enable low) while `ready` is 0 sets `err`, and `err` stays set until reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| lp_n | input | 1 | Low-power pin, active low |
| cs_n | input | 1 | Chip select, active low |
| we_n | input | 1 | Write enable, active low |
| ub_n | input | 1 | Upper byte enable, active low |
| lb_n | input | 1 | Lower byte enable, active low |
| addr | input | ADDR_W (20) | Word address; bits 4:0 carry register data |
| us_tick | input | 1 | One-cycle pulse per microsecond |
| state | output | 3 | Current power state (encoding in R2) |
| ready | output | 1 | Device may be accessed |
| retained | output | 1 | Word at `addr` keeps its data |
| err | output | 1 | Sticky protocol violation flag |

## Verification
The collision that matters is between arming-window expiry and the start of a register write: both are decided in ARM on the same clock. The bench arranges this by pulsing the tick so that the window count reaches its limit exactly in the cycle where it presents the write strobe. It then expects REGSET, and later the written top-half configuration, rather than a power-down entry. A second overlap, an access arriving during recovery while the count is still running, is provoked as well. It must set `err` without shortening the recovery.

// File: rtl/lpm_pkg.sv
`timescale 1ns/1ps
package lpm_pkg;
   typedef enum logic [2:0] {
      ST_ACTIVE  = 3'd0,
      ST_STANDBY = 3'd1,
      ST_ARM     = 3'd2,
      ST_REGSET  = 3'd3,
      ST_PAR     = 3'd4,
      ST_RMS     = 3'd5,
      ST_DPD     = 3'd6,
      ST_RECOVER = 3'd7
   } lpm_state_e;

   typedef struct packed {
      logic       dpd_off;
      logic       rms;
      logic       top;
      logic [1:0] area;
   } lpm_mode_t;

   localparam lpm_mode_t MODE_DEFAULT = '{dpd_off: 1'b1, rms: 1'b0, top: 1'b0, area: 2'b00};
   localparam int unsigned MODE_W = $bits(lpm_mode_t);

   localparam logic [1:0] AREA_FULL    = 2'b00;
   localparam logic [1:0] AREA_RSVD    = 2'b01;
   localparam logic [1:0] AREA_HALF    = 2'b10;
   localparam logic [1:0] AREA_QUARTER = 2'b11;
endpackage

// File: rtl/lpm_tick_timer.sv
`timescale 1ns/1ps
module lpm_tick_timer #(
   parameter int unsigned LIMIT = 200,
   localparam int unsigned CW = $clog2(LIMIT + 1)
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          clr,
   input  logic          tick,
   output logic [CW-1:0] count
);
   localparam logic [CW-1:0] SAT = CW'(LIMIT);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
         count <= '0;
      else if (clr)
         count <= '0;
      else if (tick && count != SAT)
         count <= count + 1'b1;
   end
endmodule

// File: rtl/lpm_mode_reg.sv
`timescale 1ns/1ps
module lpm_mode_reg
   import lpm_pkg::*;
(
   input  logic              clk,
   input  logic              rst_n,
   input  logic              capture,
   input  logic [MODE_W-1:0] cap_val,
   input  logic              commit,
   input  logic              revert,
   output lpm_mode_t         mode
);
   lpm_mode_t pend_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
         pend_q <= MODE_DEFAULT;
      else if (capture)
         pend_q <= lpm_mode_t'(cap_val);
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
         mode <= MODE_DEFAULT;
      else if (revert)
         mode <= MODE_DEFAULT;
      else if (commit)
         mode <= pend_q;
   end
endmodule

// File: rtl/lpm_region.sv
`timescale 1ns/1ps
module lpm_region
   import lpm_pkg::*;
#(
   parameter int unsigned ADDR_W = 20
) (
   input  lpm_state_e        st,
   input  lpm_mode_t         mode,
   input  logic [ADDR_W-1:0] addr,
   output logic              retained
);
   logic [1:0] hi;
   logic       in_area;
   logic       limited;
   logic       powered_off;

   assign hi = addr[ADDR_W-1 -: 2];

   always_comb begin
      case (mode.area)
         AREA_HALF:    in_area = (hi[1] == mode.top);
         AREA_QUARTER: in_area = (hi == {mode.top, mode.top});
         default:      in_area = 1'b1;
      endcase
   end

   assign powered_off = (st == ST_DPD) || (st == ST_RECOVER);
   assign limited     = (st == ST_PAR) || mode.rms;
   assign retained    = !powered_off && (!limited || in_area);
endmodule

// File: rtl/lpm_ctrl.sv
`timescale 1ns/1ps
module lpm_ctrl
   import lpm_pkg::*;
#(
   parameter int unsigned ADDR_W     = 20,
   parameter int unsigned WIN_US     = 1,
   parameter int unsigned MIN_LP_US  = 10,
   parameter int unsigned RECOVER_US = 200
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              lp_n,
   input  logic              cs_n,
   input  logic              we_n,
   input  logic              ub_n,
   input  logic              lb_n,
   input  logic [ADDR_W-1:0] addr,
   input  logic              us_tick,
   output logic [2:0]        state,
   output logic              ready,
   output logic              retained,
   output logic              err
);
   localparam int unsigned LIM_A   = (WIN_US > MIN_LP_US) ? WIN_US : MIN_LP_US;
   localparam int unsigned LIM_MAX = (LIM_A > RECOVER_US) ? LIM_A : RECOVER_US;
   localparam int unsigned CW      = $clog2(LIM_MAX + 1);

   if (ADDR_W < MODE_W) begin : g_bad_addr_w
      $error("lpm_ctrl: ADDR_W must hold the mode field");
   end
   if (WIN_US < 1 || MIN_LP_US < 1 || RECOVER_US < 1) begin : g_bad_time
      $error("lpm_ctrl: time windows must be at least one tick");
   end

   lpm_state_e    st_q, st_d;
   lpm_mode_t     mode_q;
   logic [CW-1:0] cnt;
   logic          lp_q;
   logic          lp_fall, access, wr_stb;
   logic          win_done, min_met, rec_done;
   logic          capture, commit, revert, early;
   lpm_state_e    idle_st, lp_target;

   assign lp_fall  = lp_q && !lp_n;
   assign access   = !cs_n && !(ub_n && lb_n);
   assign wr_stb   = access && !we_n;
   assign win_done = cnt >= CW'(WIN_US);
   assign min_met  = cnt >= CW'(MIN_LP_US);
   assign rec_done = cnt >= CW'(RECOVER_US);
   assign idle_st  = access ? ST_ACTIVE : ST_STANDBY;

   always_comb begin
      if (!mode_q.dpd_off)
         lp_target = ST_DPD;
      else if (mode_q.rms)
         lp_target = ST_RMS;
      else
         lp_target = ST_PAR;
   end

   always_comb begin
      st_d    = st_q;
      capture = 1'b0;
      commit  = 1'b0;
      revert  = 1'b0;
      early   = 1'b0;
      case (st_q)
         ST_ACTIVE, ST_STANDBY: st_d = lp_fall ? ST_ARM : idle_st;
         ST_ARM: begin
            if (lp_n)
               st_d = idle_st;
            else if (wr_stb) begin
               st_d    = ST_REGSET;
               capture = 1'b1;
            end else if (win_done)
               st_d = lp_target;
         end
         ST_REGSET: begin
            if (lp_n) begin
               st_d   = idle_st;
               commit = 1'b1;
            end
         end
         ST_PAR, ST_RMS: begin
            if (lp_n) begin
               st_d  = idle_st;
               early = !min_met;
            end
         end
         ST_DPD: begin
            if (lp_n) begin
               st_d   = ST_RECOVER;
               revert = 1'b1;
               early  = !min_met;
            end
         end
         ST_RECOVER: if (rec_done) st_d = idle_st;
         default: st_d = ST_STANDBY;
      endcase
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st_q <= ST_STANDBY;
         lp_q <= 1'b1;
         err  <= 1'b0;
      end else begin
         st_q <= st_d;
         lp_q <= lp_n;
         if (early || (access && !ready))
            err <= 1'b1;
      end
   end

   lpm_tick_timer #(.LIMIT(LIM_MAX)) u_timer (
      .clk   (clk),
      .rst_n (rst_n),
      .clr   (st_d != st_q),
      .tick  (us_tick),
      .count (cnt)
   );

   lpm_mode_reg u_mode (
      .clk     (clk),
      .rst_n   (rst_n),
      .capture (capture),
      .cap_val (addr[MODE_W-1:0]),
      .commit  (commit),
      .revert  (revert),
      .mode    (mode_q)
   );

   lpm_region #(.ADDR_W(ADDR_W)) u_region (
      .st       (st_q),
      .mode     (mode_q),
      .addr     (addr),
      .retained (retained)
   );

   assign state = st_q;
   assign ready = (st_q != ST_DPD) && (st_q != ST_RECOVER);
endmodule

// File: rtl/lpm_ctrl_chk.sv
`timescale 1ns/1ps
module lpm_ctrl_chk
   import lpm_pkg::*;
(
   input logic       clk,
   input logic       rst_n,
   input logic       lp_n,
   input logic       cs_n,
   input logic       we_n,
   input logic       ub_n,
   input logic       lb_n,
   input logic [2:0] st,
   input logic [4:0] mode,
   input logic       ready,
   input logic       retained,
   input logic       err
);
   logic acc, idle;
   assign acc  = !cs_n && !(ub_n && lb_n);
   assign idle = (st == ST_ACTIVE) || (st == ST_STANDBY);

   p_idle_active_r2: assert property (@(posedge clk) disable iff (!rst_n)
      idle && lp_n && acc |=> st == ST_ACTIVE);

   p_fall_arm_r3: assert property (@(posedge clk) disable iff (!rst_n)
      idle && !lp_n && $past(lp_n) |=> st == ST_ARM);

   p_regset_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
      st == ST_REGSET && !lp_n |=> $stable(mode));

   p_wr_wins_r4: assert property (@(posedge clk) disable iff (!rst_n)
      st == ST_ARM && !lp_n && acc && !we_n |=> st == ST_REGSET);

   p_dpd_exit_r7: assert property (@(posedge clk) disable iff (!rst_n)
      st == ST_DPD && lp_n |=> st == ST_RECOVER && mode == 5'h10);

   p_recover_busy_r7: assert property (@(posedge clk) disable iff (!rst_n)
      st == ST_RECOVER |-> !ready);

   p_rms_kept_r8: assert property (@(posedge clk) disable iff (!rst_n)
      st == ST_RMS |-> mode[3]);

   p_no_data_r10: assert property (@(posedge clk) disable iff (!rst_n)
      (st == ST_DPD || st == ST_RECOVER) |-> !retained);

   p_err_sticky_r11: assert property (@(posedge clk) disable iff (!rst_n)
      err |=> err);

   p_busy_access_r11: assert property (@(posedge clk) disable iff (!rst_n)
      !ready && acc |=> err);
endmodule

bind lpm_ctrl lpm_ctrl_chk u_chk (
   .clk      (clk),
   .rst_n    (rst_n),
   .lp_n     (lp_n),
   .cs_n     (cs_n),
   .we_n     (we_n),
   .ub_n     (ub_n),
   .lb_n     (lb_n),
   .st       (state),
   .mode     (mode_q),
   .ready    (ready),
   .retained (retained),
   .err      (err)
);

// File: tb/lpm_ctrl_tb.sv
`timescale 1ns/1ps
module lpm_ctrl_tb;
   localparam int WIN = 1, MINLP = 10, REC = 200;

   logic clk = 1'b0, rst_n = 1'b0;
   logic lp_n = 1'b1, cs_n = 1'b1, we_n = 1'b1, ub_n = 1'b1, lb_n = 1'b1, us_tick = 1'b0;
   logic [19:0] addr = '0;
   logic [2:0] state;
   logic ready, retained, err;

   int n_chk = 0, n_bad = 0;

   always #10 clk = ~clk;

   lpm_ctrl u_dut (
      .clk(clk), .rst_n(rst_n), .lp_n(lp_n), .cs_n(cs_n), .we_n(we_n),
      .ub_n(ub_n), .lb_n(lb_n), .addr(addr), .us_tick(us_tick),
      .state(state), .ready(ready), .retained(retained), .err(err)
   );

   // reference model
   int m_st, m_cnt;
   logic [4:0] m_mode, m_pend;
   logic m_lpq, m_err;

   function automatic logic m_ready();
      return !(m_st == 6 || m_st == 7);
   endfunction

   function automatic logic m_ret(input logic [19:0] a);
      logic in_a;
      case (m_mode[1:0])
         2'b10:   in_a = (a[19] == m_mode[2]);
         2'b11:   in_a = (a[19:18] == {m_mode[2], m_mode[2]});
         default: in_a = 1'b1;
      endcase
      if (!m_ready()) return 1'b0;
      if (m_st == 4 || m_mode[3]) return in_a;
      return 1'b1;
   endfunction

   task automatic m_reset();
      m_st = 1; m_cnt = 0; m_mode = 5'h10; m_pend = 5'h10; m_lpq = 1'b1; m_err = 1'b0;
   endtask

   task automatic m_step();
      logic acc, wr, fall;
      int nst, idle;
      acc  = !cs_n && !(ub_n && lb_n);
      wr   = acc && !we_n;
      fall = m_lpq && !lp_n;
      idle = acc ? 0 : 1;
      nst  = m_st;
      if (acc && !m_ready()) m_err = 1'b1;
      case (m_st)
         0, 1: nst = fall ? 2 : idle;
         2: if (lp_n) nst = idle;
            else if (wr) begin nst = 3; m_pend = addr[4:0]; end
            else if (m_cnt >= WIN) nst = !m_mode[4] ? 6 : (m_mode[3] ? 5 : 4);
         3: if (lp_n) begin nst = idle; m_mode = m_pend; end
         4, 5: if (lp_n) begin nst = idle; if (m_cnt < MINLP) m_err = 1'b1; end
         6: if (lp_n) begin nst = 7; m_mode = 5'h10; if (m_cnt < MINLP) m_err = 1'b1; end
         default: if (m_cnt >= REC) nst = idle;
      endcase
      if (nst != m_st) m_cnt = 0;
      else if (us_tick && m_cnt != REC) m_cnt++;
      m_st  = nst;
      m_lpq = lp_n;
   endtask

   task automatic check(input string tag, input string what, input int act, input int exp);
      n_chk++;
      if (act != exp) begin
         n_bad++;
         $display("FAIL %s %s: actual %0d expected %0d at %0t", tag, what, act, exp, $time);
      end
   endtask

   // one clock: drive after the falling edge, compare, advance model
   task automatic cyc(input logic lp, input logic cs, input logic we, input logic ub,
                      input logic lb, input logic [19:0] a, input logic tk, input string tag);
      lp_n = lp; cs_n = cs; we_n = we; ub_n = ub; lb_n = lb; addr = a; us_tick = tk;
      #1;
      check(tag, "state", int'(state), m_st);
      check(tag, "ready", int'(ready), int'(m_ready()));
      check(tag, "err", int'(err), int'(m_err));
      check(tag, "retained", int'(retained), int'(m_ret(a)));
      m_step();
      @(negedge clk);
   endtask

   task automatic do_reset();
      rst_n = 1'b0; lp_n = 1'b1; cs_n = 1'b1; we_n = 1'b1; ub_n = 1'b1; lb_n = 1'b1; us_tick = 1'b0;
      repeat (3) @(negedge clk);
      m_reset();
      rst_n = 1'b1;
   endtask

   task automatic idle_for(input int n, input string tag);
      for (int i = 0; i < n; i++) cyc(1, 1, 1, 1, 1, 20'($urandom), 1, tag);
   endtask

   task automatic low_for(input int n, input string tag);
      for (int i = 0; i < n; i++) cyc(0, 1, 1, 1, 1, 20'($urandom), 1, tag);
   endtask

   task automatic reg_set(input logic [4:0] v, input string tag);
      cyc(1, 1, 1, 1, 1, 20'h0, 0, tag);
      cyc(0, 1, 1, 1, 1, 20'h0, 0, tag);
      cyc(0, 0, 0, 0, 1, {15'h7ABC, v}, 0, tag);
      cyc(0, 1, 1, 1, 1, 20'h0, 1, tag);
      cyc(1, 1, 1, 1, 1, 20'h0, 0, tag);
      cyc(1, 1, 1, 1, 1, 20'h0, 0, tag);
   endtask

   initial begin
      #(20ns * 150000);
      n_bad++;
      $display("FAIL watchdog expired");
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
   end

   initial begin
      void'($urandom(32'h1F2E3D4C));
      m_reset();
      @(negedge clk);
      // R1: reset values, visible while reset is held
      check("R1", "state", int'(state), 1);
      check("R1", "ready", int'(ready), 1);
      check("R1", "err", int'(err), 0);
      do_reset();
      cyc(1, 1, 1, 1, 1, 20'hFFFFF, 0, "R1");

      // R2: idle tracking
      cyc(1, 0, 1, 0, 1, 20'h1, 0, "R2");
      cyc(1, 0, 1, 1, 0, 20'h2, 0, "R2");
      cyc(1, 0, 1, 1, 1, 20'h3, 0, "R2");
      cyc(1, 1, 1, 0, 0, 20'h4, 0, "R2");
      cyc(1, 1, 1, 1, 1, 20'h5, 0, "R2");

      // R3: write with lp_n high is ignored; next entry uses defaults (PAR, full)
      cyc(1, 0, 0, 0, 0, 20'h0001B, 0, "R3");
      cyc(1, 1, 1, 1, 1, 20'h0, 0, "R3");
      low_for(14, "R5");
      idle_for(3, "R5");

      // R3/R8/R9: reduced size, bottom quarter
      reg_set(5'h1B, "R3");
      cyc(1, 1, 1, 1, 1, 20'h3FFFF, 0, "R9");
      cyc(1, 1, 1, 1, 1, 20'h40000, 0, "R9");
      cyc(1, 1, 1, 1, 1, 20'hFFFFF, 0, "R9");
      low_for(14, "R8");
      idle_for(3, "R8");
      low_for(14, "R8");
      idle_for(3, "R8");

      // R4: write in the cycle the window expires
      cyc(0, 1, 1, 1, 1, 20'h0, 1, "R4");
      cyc(0, 1, 1, 1, 1, 20'h0, 1, "R4");
      cyc(0, 0, 0, 1, 0, 20'h00016, 1, "R4");
      cyc(0, 1, 1, 1, 1, 20'h0, 1, "R4");
      cyc(1, 1, 1, 1, 1, 20'h0, 0, "R4");
      cyc(1, 1, 1, 1, 1, 20'h0, 0, "R4");
      low_for(6, "R9");
      cyc(0, 1, 1, 1, 1, 20'h80000, 1, "R9");
      cyc(0, 1, 1, 1, 1, 20'h7FFFF, 1, "R9");
      low_for(6, "R9");
      idle_for(2, "R9");

      // R6: early exit
      do_reset();
      low_for(4, "R6");
      idle_for(3, "R6");

      // R5/R7/R10: deep power-down and recovery, then defaults restored
      do_reset();
      reg_set(5'h00, "R5");
      low_for(14, "R10");
      idle_for(REC + 5, "R7");
      low_for(14, "R7");
      idle_for(3, "R7");

      // R11: access during recovery
      reg_set(5'h00, "R11");
      low_for(14, "R11");
      idle_for(5, "R11");
      cyc(1, 0, 1, 0, 0, 20'h12345, 1, "R11");
      idle_for(REC + 5, "R11");

      // R9: reserved area code behaves as full array
      do_reset();
      reg_set(5'h11, "R9");
      low_for(20, "R9");
      idle_for(2, "R9");

      // random mix
      do_reset();
      begin
         logic lp = 1'b1;
         for (int i = 0; i < 4000; i++) begin
            if ($urandom_range(0, 29) == 0) lp = ~lp;
            cyc(lp, 1'($urandom_range(0, 3) != 0), 1'($urandom), 1'($urandom), 1'($urandom),
                20'($urandom), 1'($urandom), "R2");
         end
      end

      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
   end
endmodule